// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Flags

This block is the 8-bit arithmetic slice of a small CPU core. It holds an accumulator, six general registers and a four-bit flag set. It executes one-byte register-source opcodes of three kinds: subtract from the accumulator, add to the accumulator, and add with carry-in. Each opcode reads the accumulator and one selected register. The result goes back into the accumulator, and the zero, subtract, half-carry and carry flags are updated.

The surrounding core presents an opcode with a one-cycle valid strobe while the unit is idle. The unit then stays busy for a fixed number of cycles and marks completion with a one-cycle done pulse. Opcodes outside the supported set produce a one-cycle illegal pulse instead, and leave all state alone. A register load port lets the core seed any register, or the flag nibble, while the unit is idle.

Top module: `acc_arith_unit`

## Requirements
- R1: Opcode bits [7:3] select the operation: 5'b10010 (0x90..0x97) is subtract, 5'b10000 (0x80..0x87) is add, 5'b10001 (0x88..0x8F) is add-with-carry. Opcode bits [2:0] select the operand: 0..5 are B, C, D, E, H and L, and 7 is the accumulator.
- R2: When an opcode is accepted at a clock edge, done is high for exactly one cycle, starting 4 edges later. The accumulator and flags take their new values at that same edge. Busy is high from the accepting edge until done rises.
- R3: Subtract writes (A - r) mod 256 to the accumulator. Z is set exactly when that result is 0x00, and N is set to 1.
- R4: For subtract, H is set when A[3:0] < r[3:0] and C is set when A < r, both compared unsigned. Examples: 0xF0-0x0F gives 0xE1 with H=1, C=0; 0x0E-0xFF gives 0x0F with H=1, C=1; 0x00-0xFF gives 0x01 with H=1, C=1.
- R5: Add writes (A + r) mod 256 and add-with-carry writes (A + r + C) mod 256. C is the carry flag held before the operation, and add ignores it. Both clear N and set Z exactly when the result is 0x00.
- R6: For add and add-with-carry, H is set when A[3:0] + r[3:0] + carry-in exceeds 0xF, and C is set when the 9-bit sum exceeds 0xFF. Examples: A=0x0E added to itself with carry-in 1 gives 0x1D with H=1, C=0; A=0xF0 added to itself gives 0xE0 with C=1, H=0.
- R7: flags_out holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, and bits 3:0 always read 0. A load with select 6 writes ld_data[7:4] into the flags.
- R8: A load with select 0..5 writes B..L, and select 7 writes the accumulator; the new value is visible one cycle later. While busy is high, loads and opcode strobes are ignored, so the operands are those present when the opcode was accepted.
- R9: Every other opcode, including the x6 operand slot of each group, raises illegal for one cycle after the accepting edge. It does not raise busy or done, and it leaves the accumulator and flags unchanged.
- R10: After reset all registers and flags are zero, and busy, done and illegal are low.
- R11: Subtracting the accumulator from itself (0x97) with A=0xFF leaves A=0x00 and flags_out=0xC0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode strobe, honoured only while idle |
| opcode | input | 8 | Opcode byte |
| ld_en | input | 1 | Register load enable |
| ld_sel | input | 3 | Load target: 0..5 B..L, 6 flags, 7 accumulator |
| ld_data | input | DATA_W | Load value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle unsupported-opcode pulse |
| acc_out | output | DATA_W | Accumulator value |
| flags_out | output | 8 | Flag byte {Z,N,H,C,0000} |

## Verification
The bench builds the unit with its default 8-bit data width and 4-cycle latency. At that width every accumulator value is reachable. Each accumulator value is paired with sixteen operands of differing nibbles, under all three operations and both carry-in states, so every borrow and carry boundary of both nibbles is crossed. Because the opcode byte is small, all 256 opcodes are driven to check the legal/illegal split, and the 4-cycle window makes the busy and done timing checkable edge by edge.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OPC_W    = 8;
    localparam int IDX_W    = 3;
    localparam int NSLOT    = 1 << IDX_W;
    localparam int FLAG_W   = 4;
    localparam int FLAG_MSB = 7;

    localparam logic [IDX_W-1:0] SEL_FLAGS = 3'd6;
    localparam logic [IDX_W-1:0] SEL_ACC   = 3'd7;

    localparam logic [4:0] GRP_ADD = 5'b10000;
    localparam logic [4:0] GRP_ADC = 5'b10001;
    localparam logic [4:0] GRP_SUB = 5'b10010;

    typedef enum logic [1:0] {
        K_ADD = 2'd0,
        K_ADC = 2'd1,
        K_SUB = 2'd2
    } alu_kind_e;

    typedef struct packed {
        logic             legal;
        alu_kind_e        kind;
        logic [IDX_W-1:0] src;
    } dec_t;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);
    logic [4:0] grp;
    logic       slot_ok;

    assign grp     = opcode[OPC_W-1:IDX_W];
    assign slot_ok = (opcode[IDX_W-1:0] != SEL_FLAGS);

    always_comb begin
        dec.src   = opcode[IDX_W-1:0];
        dec.kind  = K_ADD;
        dec.legal = 1'b0;
        unique case (grp)
            GRP_ADD: begin dec.kind = K_ADD; dec.legal = slot_ok; end
            GRP_ADC: begin dec.kind = K_ADC; dec.legal = slot_ok; end
            GRP_SUB: begin dec.kind = K_SUB; dec.legal = slot_ok; end
            default: begin dec.kind = K_ADD; dec.legal = 1'b0; end
        endcase
    end

    // R9: the x6 operand slot is never legal
    always_comb begin
        assert_hole_illegal_R9: assert (!(dec.legal && dec.src == SEL_FLAGS));
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_kind_e         kind,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output flags_t            fl
);
    localparam int HALF_W = DATA_W / 2;

    logic              ci;
    logic [DATA_W:0]   wide;
    logic [HALF_W:0]   nib;

    assign ci = (kind == K_ADC) ? cin : 1'b0;

    always_comb begin
        if (kind == K_SUB) begin
            wide = {1'b0, a} - {1'b0, b};
            nib  = {1'b0, a[HALF_W-1:0]} - {1'b0, b[HALF_W-1:0]};
        end else begin
            wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
            nib  = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, ci};
        end
    end

    assign res  = wide[DATA_W-1:0];
    assign fl.z = (res == '0);
    assign fl.n = (kind == K_SUB);
    assign fl.h = nib[HALF_W];
    assign fl.c = wide[DATA_W];

    // R4: a subtract borrow must agree with an unsigned compare of the operands
    always_comb begin
        if (kind == K_SUB) begin
            assert_sub_borrow_R4: assert (fl.c == (a < b));
        end
    end
endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
    import acc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              wb_en,
    input  logic [DATA_W-1:0] wb_data,
    input  flags_t            wb_flags,
    input  logic [IDX_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] acc,
    output flags_t            flags
);
    logic [DATA_W-1:0] slot [NSLOT];
    flags_t            fl_q;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i == int'(SEL_FLAGS)) begin : g_hole
            assign slot[i] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wb_en && i == int'(SEL_ACC)) begin
                    q <= wb_data;
                end else if (ld_en && ld_sel == IDX_W'(i)) begin
                    q <= ld_data;
                end
            end
            assign slot[i] = q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else if (wb_en) begin
            fl_q <= wb_flags;
        end else if (ld_en && ld_sel == SEL_FLAGS) begin
            fl_q <= flags_t'(ld_data[FLAG_MSB -: FLAG_W]);
        end
    end

    assign rd_data = slot[rd_sel];
    assign acc     = slot[SEL_ACC];
    assign flags   = fl_q;

    // R8: an accumulator load shows up on the next cycle
    assert_acc_load_R8: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !wb_en && ld_sel == SEL_ACC) |=> (acc == $past(ld_data)));
endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic op_valid,
    input  dec_t dec,
    output logic busy,
    output logic done,
    output logic illegal,
    output logic commit,
    output dec_t pend
);
    localparam int CNT_W = $clog2(LATENCY + 1);

    logic             busy_q;
    logic             done_q;
    logic             ill_q;
    logic [CNT_W-1:0] cnt_q;
    dec_t             pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            cnt_q  <= '0;
            pend_q <= '0;
        end else begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
            if (busy_q) begin
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end else if (op_valid) begin
                if (dec.legal) begin
                    busy_q <= 1'b1;
                    cnt_q  <= CNT_W'(LATENCY);
                    pend_q <= dec;
                end else begin
                    ill_q <= 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign illegal = ill_q;
    assign commit  = busy_q && (cnt_q == CNT_W'(1));
    assign pend    = pend_q;

    // R2: done is a single-cycle pulse that closes a busy window
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
    assert_busy_ends_in_done_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    // R9: illegal only follows a strobe taken while idle
    assert_illegal_cause_R9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> ($past(op_valid) && !$past(busy) && !busy));
endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
    import acc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic              ld_en,
    input  logic [2:0]        ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [DATA_W-1:0] acc_out,
    output logic [7:0]        flags_out
);
    dec_t              dec;
    dec_t              pend;
    logic              commit;
    logic              ld_ok;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_fl;
    flags_t            flags;

    acc_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    acc_seq #(.LATENCY(LATENCY)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .dec      (dec),
        .busy     (busy),
        .done     (done),
        .illegal  (illegal),
        .commit   (commit),
        .pend     (pend)
    );

    assign ld_ok = ld_en && !busy;

    acc_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_ok),
        .ld_sel   (ld_sel),
        .ld_data  (ld_data),
        .wb_en    (commit),
        .wb_data  (alu_res),
        .wb_flags (alu_fl),
        .rd_sel   (pend.src),
        .rd_data  (opnd),
        .acc      (acc),
        .flags    (flags)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .kind (pend.kind),
        .a    (acc),
        .b    (opnd),
        .cin  (flags.c),
        .res  (alu_res),
        .fl   (alu_fl)
    );

    assign acc_out   = acc;
    assign flags_out = {flags, 4'b0000};

    // R3: zero flag matches the accumulator written at completion
    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (flags_out[7] == (acc_out == '0)));
    // R5: subtract indicator follows the kind of the finished operation
    assert_sub_flag_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (flags_out[6] == (pend.kind == K_SUB)));
    // R9: a rejected opcode leaves the accumulator and flags untouched
    assert_illegal_keeps_state_R9: assert property (@(posedge clk) disable iff (rst)
        (illegal && !$past(ld_en)) |-> ($stable(acc_out) && $stable(flags_out)));
endmodule

// File: tb/acc_arith_unit_bench.sv
module acc_arith_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic       ld_en = 1'b0;
    logic [2:0] ld_sel = 3'd0;
    logic [7:0] ld_data = 8'h00;
    logic       busy, done, illegal;
    logic [7:0] acc_out, flags_out;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] m_reg [8];
    logic [3:0] m_fl;

    always #2 clk = ~clk;

    acc_arith_unit u_acc_arith_unit (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .opcode    (opcode),
        .ld_en     (ld_en),
        .ld_sel    (ld_sel),
        .ld_data   (ld_data),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .acc_out   (acc_out),
        .flags_out (flags_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] sel, input logic [7:0] val);
        ld_en = 1'b1; ld_sel = sel; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
        if (sel == 3'd6) m_fl = val[7:4];
        else m_reg[sel] = val;
    endtask

    // Expected result from the requirements (R3..R6)
    task automatic model(input logic [7:0] opc, output logic [7:0] r, output logic [3:0] f);
        int a, b, ci, s, lo;
        bit z, n, h, c;
        a  = int'(m_reg[7]);
        b  = int'(m_reg[opc[2:0]]);
        ci = (opc[7:3] == 5'b10001) ? int'(m_fl[0]) : 0;
        if (opc[7:3] == 5'b10010) begin
            s  = (a - b) & 255;
            c  = a < b;
            h  = (a & 15) < (b & 15);
            n  = 1'b1;
        end else begin
            s  = a + b + ci;
            lo = (a & 15) + (b & 15) + ci;
            c  = s > 255;
            h  = lo > 15;
            s  = s & 255;
            n  = 1'b0;
        end
        z = (s == 0);
        r = 8'(s);
        f = {z, n, h, c};
    endtask

    function automatic bit is_legal(input logic [7:0] opc);
        return (opc[7:3] == 5'b10000 || opc[7:3] == 5'b10001 || opc[7:3] == 5'b10010)
               && opc[2:0] != 3'd6;
    endfunction

    task automatic run_op(input logic [7:0] opc, input string req);
        logic [7:0] er;
        logic [3:0] ef;
        bit tim_ok;
        logic [7:0] acc0, fl0;
        acc0 = acc_out; fl0 = flags_out;
        op_valid = 1'b1; opcode = opc;
        @(negedge clk);
        op_valid = 1'b0;
        if (!is_legal(opc)) begin
            // R9: pulse, no busy, state unchanged
            chk(illegal && !busy && !done, "R9", "illegal pulse", {busy, done, illegal}, 3'b001);
            chk(acc_out == acc0 && flags_out == fl0, "R9", "state kept",
                {acc_out, flags_out}, {acc0, fl0});
            @(negedge clk);
            chk(!illegal && !busy, "R9", "pulse width", {busy, illegal}, 2'b00);
            return;
        end
        model(opc, er, ef);
        tim_ok = busy && !done && !illegal;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            tim_ok &= busy && !done;
        end
        @(negedge clk);
        tim_ok &= done && !busy;
        chk(tim_ok, "R2", "busy/done timing", {busy, done}, 2'b01);
        chk(acc_out == er, req, $sformatf("acc op=%02h", opc), acc_out, er);
        chk(flags_out == {ef, 4'b0000}, req, $sformatf("flags op=%02h", opc),
            flags_out, {ef, 4'b0000});
        m_reg[7] = er;
        m_fl = ef;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_fl = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk(acc_out == 8'h00 && flags_out == 8'h00, "R10", "acc/flags",
            {acc_out, flags_out}, 16'h0000);
        chk(!busy && !done && !illegal, "R10", "status", {busy, done, illegal}, 3'b000);

        // R7: flag load and layout
        load(3'd6, 8'hFF);
        chk(flags_out == 8'hF0, "R7", "flag load FF", flags_out, 8'hF0);
        load(3'd6, 8'hA5);
        chk(flags_out == 8'hA0, "R7", "flag load A5", flags_out, 8'hA0);

        // R8: accumulator load
        load(3'd7, 8'h5C);
        chk(acc_out == 8'h5C, "R8", "acc load", acc_out, 8'h5C);

        // R4: directed subtract vectors through B (0x90)
        begin
            logic [7:0] va [6] = '{8'hFF, 8'hF0, 8'h0F, 8'h0E, 8'h00, 8'h00};
            logic [7:0] vb [6] = '{8'h0F, 8'h0F, 8'hF0, 8'hFF, 8'h0F, 8'hFF};
            logic [7:0] vr [6] = '{8'hF0, 8'hE1, 8'h1F, 8'h0F, 8'hF1, 8'h01};
            logic [1:0] vf [6] = '{2'b00, 2'b10, 2'b01, 2'b11, 2'b11, 2'b11};
            for (int i = 0; i < 6; i++) begin
                load(3'd7, va[i]);
                load(3'd0, vb[i]);
                run_op(8'h90, "R4");
                chk(acc_out == vr[i] && flags_out[5:4] == vf[i], "R4", "vector",
                    {acc_out, flags_out[5:4]}, {vr[i], vf[i]});
            end
        end

        // R11: self subtract from 0xFF
        load(3'd7, 8'hFF);
        run_op(8'h97, "R11");
        chk(acc_out == 8'h00 && flags_out == 8'hC0, "R11", "self sub",
            {acc_out, flags_out}, 16'h00C0);

        // R6: add-with-carry self vectors
        load(3'd7, 8'h0E); load(3'd6, 8'h10);
        run_op(8'h8F, "R6");
        chk(acc_out == 8'h1D && flags_out[5:4] == 2'b10, "R6", "adc 0E+0E+1",
            {acc_out, flags_out}, 16'h1D20);
        load(3'd7, 8'hF0); load(3'd6, 8'h00);
        run_op(8'h87, "R6");
        chk(acc_out == 8'hE0 && flags_out[5:4] == 2'b01, "R6", "add F0+F0",
            {acc_out, flags_out}, 16'hE010);

        // R8: loads and strobes ignored while busy
        load(3'd7, 8'h50);
        load(3'd0, 8'h10);
        op_valid = 1'b1; opcode = 8'h90;
        @(negedge clk);
        op_valid = 1'b0;
        ld_en = 1'b1; ld_sel = 3'd0; ld_data = 8'h33;
        @(negedge clk);
        ld_sel = 3'd7; ld_data = 8'h99;
        @(negedge clk);
        ld_en = 1'b0;
        op_valid = 1'b1; opcode = 8'h80;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        chk(done && acc_out == 8'h40, "R8", "operands frozen", acc_out, 8'h40);
        @(negedge clk);
        chk(!busy, "R8", "strobe during busy ignored", busy, 0);
        m_reg[7] = 8'h40; m_fl = 4'b0100;
        run_op(8'h90, "R8");
        chk(acc_out == 8'h30, "R8", "B unchanged", acc_out, 8'h30);

        // R1 / R9: every opcode byte
        for (int o = 0; o < 256; o++) begin
            load(3'd7, 8'(o * 37 + 11));
            run_op(8'(o), "R1");
        end

        // R3 / R5 / R6 sweep: all accumulators, 16 operand patterns, 3 kinds
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 16; k++) begin
                logic [2:0] src;
                logic [7:0] b;
                src = 3'(k % 6);
                b   = 8'(k * 16 + ((k * 7 + 3) & 15));
                load(src, b);
                load(3'd7, 8'(a)); load(3'd6, 8'(((a ^ k) & 1) << 4));
                run_op({5'b10010, src}, "R3");
                load(3'd7, 8'(a)); load(3'd6, 8'(((a ^ k) & 1) << 4));
                run_op({5'b10000, src}, "R5");
                load(3'd7, 8'(a)); load(3'd6, 8'(((a ^ k) & 1) << 4));
                run_op({5'b10001, src}, "R6");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule